// File: doc/BRIEF.md
# SAR ADC Serial Host Sequencer

This block runs the host side of a 14-bit multiplexed successive-approximation converter that gives no busy indication. When it accepts a start request it drives the convert strobe low for one cycle and then high. It holds the strobe high for a programmable number of system-clock cycles, which must cover the conversion time, and then lowers it to open a single transfer window. The configuration write and the result read both happen inside that window.

While the strobe is low, the block produces a mode-0 serial clock (idle low, data launched on falling edges, sampled on rising edges) from the system clock, using a programmable half-period. It shifts the 14-bit configuration word out MSB first and captures the converter's serial output on every falling clock edge. The result MSB is already on the data line when the window opens. With readback enabled, the window runs 28 clock pulses instead of 14, so the configuration tied to the result is captured after the result. At the last falling edge the strobe goes high again and the block presents the captured words with a one-cycle valid pulse. A programmable minimum cycle time spaces out accepted starts.

Top module: `adcs_host`

## Requirements
- R1: While reset is high and in the first cycle after it, cnv_o, sck_o, din_o, result_valid, result_data and result_cfg are all 0.
- R2: A start sampled high in the idle state is accepted at that clock edge (edge A). cnv_o is low after edge A, high after edge A+1, and goes low after edge A+1+T, where T is conv_ticks (0 treated as 1).
- R3: sck_o is low whenever cnv_o is high. Its first rising edge comes H cycles after cnv_o falls, and every high and low level lasts H cycles, where H is half_ticks (0 treated as 1).
- R4: When cnv_o falls, din_o carries bit 13 of the latched configuration word. din_o changes only with falling sck_o edges, so the first 14 rising edges see bits 13 down to 0 in that order. din_o is 0 after the 14th falling edge.
- R5: A window contains exactly 14 sck_o pulses with readback disabled and exactly 28 with readback enabled.
- R6: sdo_i is sampled at each falling sck_o edge. result_data is the first 14 samples, with the first sample at bit 13.
- R7: With readback enabled, result_cfg is samples 15 to 28, with sample 15 at bit 13. With readback disabled, result_cfg is 0.
- R8: At the edge that makes the last falling sck_o edge, cnv_o goes high and result_valid goes high for exactly one cycle. This is edge A+1+T+2·N·H, where N is 14 or 28.
- R9: A start that arrives while the block is not idle is ignored. With start held high, successive accept edges are max(M, 3+T+2·N·H) cycles apart, where M is min_cycle.
- R10: cfg_word and rdback_en are latched at edge A. Changing them later in the cycle changes neither the bits on din_o nor the number of clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion cycle |
| cfg_word | input | DW | Configuration word to send in the window |
| rdback_en | input | 1 | Capture the configuration readback (28 clocks) |
| conv_ticks | input | TW | Strobe-high hold time in cycles |
| half_ticks | input | HW | Serial clock half-period in cycles |
| min_cycle | input | MW | Minimum spacing of accepted starts in cycles |
| cnv_o | output | 1 | Convert strobe |
| sck_o | output | 1 | Serial clock, mode 0 |
| din_o | output | 1 | Serial configuration data to the converter |
| sdo_i | input | 1 | Serial result data from the converter |
| result_valid | output | 1 | One-cycle pulse when results are presented |
| result_data | output | DW | Captured conversion result |
| result_cfg | output | DW | Captured configuration readback, or 0 |

## Verification
All timing is counted from the accept edge A. The strobe's window fall is due 1+T edges after A, the first serial clock rise H edges after that, and result_valid 1+T+2·N·H edges after A. The bench samples on the falling system-clock edge. It records the sample index at which each event first shows, compares that index with the arithmetic value, and reads results only once the expected valid index has passed. Start-spacing is checked as the distance between consecutive valid pulses, which equals the spacing of the accept edges because every cycle in a run has the same length.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_CONV,
    ST_XFER,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/adcs_sck_gen.sv
module adcs_sck_gen #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          sck,
  output logic          rise_stb,
  output logic          fall_stb
);
  logic [HW-1:0] ph;
  logic [HW-1:0] lim;
  logic          tog;

  assign lim      = (half == '0) ? HW'(1) : half;
  assign tog      = run && (ph == lim - 1'b1);
  assign rise_stb = tog && !sck;
  assign fall_stb = tog && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph  <= '0;
      sck <= 1'b0;
    end else if (tog) begin
      ph  <= '0;
      sck <= ~sck;
    end else begin
      ph  <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/adcs_cfg_tx.sv
module adcs_cfg_tx #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] word,
  input  logic          shift,
  output logic          din
);
  logic [DW-2:0] rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      din  <= 1'b0;
      rest <= '0;
    end else if (load) begin
      din  <= word[DW-1];
      rest <= word[DW-2:0];
    end else if (shift) begin
      din  <= rest[DW-2];
      rest <= {rest[DW-3:0], 1'b0};
    end
  end
endmodule

// File: rtl/adcs_res_rx.sv
module adcs_res_rx #(
  parameter int DW = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            sample,
  input  logic            sdo,
  output logic [2*DW-1:0] nxt
);
  logic [2*DW-2:0] acc;

  assign nxt = {acc, sdo};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
    end else if (sample) begin
      acc <= nxt[2*DW-2:0];
    end
  end
endmodule

// File: rtl/adcs_host.sv
module adcs_host
  import adcs_pkg::*;
#(
  parameter int DW = 14,
  parameter int TW = 16,
  parameter int HW = 8,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] cfg_word,
  input  logic          rdback_en,
  input  logic [TW-1:0] conv_ticks,
  input  logic [HW-1:0] half_ticks,
  input  logic [MW-1:0] min_cycle,
  output logic          cnv_o,
  output logic          sck_o,
  output logic          din_o,
  input  logic          sdo_i,
  output logic          result_valid,
  output logic [DW-1:0] result_data,
  output logic [DW-1:0] result_cfg
);
  localparam int NW = $clog2(2 * DW + 1);

  seq_state_t      state;
  logic [TW-1:0]   cnt;
  logic [TW-1:0]   conv_lim;
  logic [NW-1:0]   nfall;
  logic [NW-1:0]   last_fall;
  logic [MW-1:0]   cyc;
  logic [DW-1:0]   cfg_q;
  logic            rb_q;
  logic            win_open;
  logic            run;
  logic            rise_stb;
  logic            fall_stb;
  logic [2*DW-1:0] rx_nxt;

  assign conv_lim  = (conv_ticks == '0) ? TW'(1) : conv_ticks;
  assign last_fall = rb_q ? NW'(2 * DW - 1) : NW'(DW - 1);
  assign win_open  = (state == ST_CONV) && (cnt == conv_lim - 1'b1);
  assign run       = (state == ST_XFER);

  adcs_sck_gen #(.HW(HW)) u_sck (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .half     (half_ticks),
    .sck      (sck_o),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  adcs_cfg_tx #(.DW(DW)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .load  (win_open),
    .word  (cfg_q),
    .shift (fall_stb),
    .din   (din_o)
  );

  adcs_res_rx #(.DW(DW)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (win_open),
    .sample (fall_stb),
    .sdo    (sdo_i),
    .nxt    (rx_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnv_o        <= 1'b0;
      result_valid <= 1'b0;
      result_data  <= '0;
      result_cfg   <= '0;
      cfg_q        <= '0;
      rb_q         <= 1'b0;
      cnt          <= '0;
      nfall        <= '0;
      cyc          <= '0;
    end else begin
      result_valid <= 1'b0;
      if (cyc != '1) cyc <= cyc + 1'b1;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ARM;
            cnv_o <= 1'b0;
            cfg_q <= cfg_word;
            rb_q  <= rdback_en;
            cyc   <= MW'(1);
          end
        end
        ST_ARM: begin
          cnv_o <= 1'b1;
          cnt   <= '0;
          state <= ST_CONV;
        end
        ST_CONV: begin
          if (win_open) begin
            cnv_o <= 1'b0;
            nfall <= '0;
            state <= ST_XFER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (fall_stb) begin
            nfall <= nfall + 1'b1;
            if (nfall == last_fall) begin
              state        <= ST_GAP;
              cnv_o        <= 1'b1;
              result_valid <= 1'b1;
              if (rb_q) begin
                result_data <= rx_nxt[2*DW-1:DW];
                result_cfg  <= rx_nxt[DW-1:0];
              end else begin
                result_data <= rx_nxt[DW-1:0];
                result_cfg  <= '0;
              end
            end
          end
        end
        ST_GAP: begin
          if (({1'b0, cyc} + 1'b1) >= {1'b0, min_cycle}) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r3_sck_low_while_cnv_high: assert property (@(posedge clk) disable iff (rst)
    cnv_o |-> !sck_o);

  a_r4_din_steady_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> $stable(din_o));

  a_r8_valid_single_cycle: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  a_r8_valid_after_last_fall: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> ($past(sck_o) && cnv_o && !sck_o));

  a_r5_rise_only_in_window: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> !cnv_o);
endmodule

// File: tb/adcs_host_tb.sv
module adcs_host_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rdback_en = 1'b0;
  logic        sdo = 1'b0;
  logic [13:0] cfg_word = '0;
  logic [15:0] conv_ticks = 16'd1;
  logic [7:0]  half_ticks = 8'd1;
  logic [15:0] min_cycle = 16'd4;
  logic        cnv, sck, din, valid;
  logic [13:0] rdata, rcfg;

  int checks = 0;
  int fails = 0;

  always #(CLK_P / 2) clk = ~clk;

  adcs_host u_dut (
    .clk (clk), .rst (rst), .start (start), .cfg_word (cfg_word),
    .rdback_en (rdback_en), .conv_ticks (conv_ticks), .half_ticks (half_ticks),
    .min_cycle (min_cycle), .cnv_o (cnv), .sck_o (sck), .din_o (din),
    .sdo_i (sdo), .result_valid (valid), .result_data (rdata), .result_cfg (rcfg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  logic [13:0] res_next = '0;
  logic [13:0] cfg_eff = 14'h2A5B;
  logic [13:0] conv_res = '0;
  logic [13:0] conv_cfg = '0;
  logic [27:0] seq = '0;
  logic [13:0] din_sh = '0;
  int idx = 0;
  int din_cnt = 0;

  always @(posedge cnv) begin
    conv_res = res_next;
    conv_cfg = cfg_eff;
  end
  always @(negedge cnv) begin
    seq = {conv_res, conv_cfg};
    idx = 0;
    sdo = seq[27];
    din_cnt = 0;
  end
  always @(posedge sck) begin
    if (din_cnt < 14) begin
      din_sh = {din_sh[12:0], din};
      din_cnt++;
      if (din_cnt == 14) cfg_eff = din_sh;
    end
  end
  always @(negedge sck) begin
    idx++;
    sdo = (idx < 28) ? seq[27 - idx] : 1'b0;
  end

  // monitor, sampled away from the active edge
  int nc = 0;
  logic pc = 1'b0;
  logic ps = 1'b0;
  int t_fall = -1;
  int t_rise1 = -1;
  int t_valid = -1;
  int t_valid_prev = -1;
  int n_valid = 0;
  int n_rise = 0;
  logic [13:0] got_d = '0;
  logic [13:0] got_c = '0;
  logic got_din = 1'b0;

  always @(negedge clk) begin
    nc++;
    if (!ps && sck) begin
      n_rise++;
      if (t_rise1 < 0) t_rise1 = nc;
    end
    if (pc && !cnv) t_fall = nc;
    if (valid) begin
      n_valid++;
      t_valid_prev = t_valid;
      t_valid = nc;
      got_d = rdata;
      got_c = rcfg;
      got_din = din;
    end
    pc = cnv;
    ps = sck;
  end

  logic [13:0] prev_cfg = 14'h2A5B;

  task automatic run_one(input int t, input int h, input bit rb,
                         input logic [13:0] cfg, input logic [13:0] res,
                         input bit disturb);
    int heff, n, d, t0, nv0;
    heff = (h == 0) ? 1 : h;
    n = rb ? 28 : 14;
    d = 1 + t + 2 * n * heff;
    @(negedge clk); #1;
    conv_ticks = 16'(t);
    half_ticks = 8'(h);
    rdback_en = rb;
    cfg_word = cfg;
    res_next = res;
    n_rise = 0;
    t_rise1 = -1;
    nv0 = n_valid;
    t0 = nc;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      repeat (t + 4) @(negedge clk);
      #1;
      cfg_word = ~cfg;
      rdback_en = !rb;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    while (nc < t0 + d + 3) @(negedge clk);
    #1;
    chk(n_valid == nv0 + 1, "R8 single valid pulse", n_valid - nv0, 1);
    chk(t_valid == t0 + d + 1, "R8 valid timing", t_valid - t0, d + 1);
    chk(cnv && !sck, "R8 strobe high after window", int'(cnv), 1);
    chk(t_fall == t0 + 2 + t, "R2 strobe window fall", t_fall - t0, 2 + t);
    chk(t_rise1 == t0 + 2 + t + heff, "R3 first sck rise", t_rise1 - t0, 2 + t + heff);
    chk(n_rise == n, "R5 sck pulse count", n_rise, n);
    chk(din_sh == cfg && din_cnt == 14, "R4 din word", int'(din_sh), int'(cfg));
    chk(!got_din, "R4 din low after word", int'(got_din), 0);
    chk(got_d == res, "R6 result data", int'(got_d), int'(res));
    chk(got_c == (rb ? prev_cfg : 14'h0), "R7 readback field", int'(got_c),
        rb ? int'(prev_cfg) : 0);
    if (disturb) begin
      chk(din_sh == cfg && n_rise == n, "R10 late input change ignored",
          int'(din_sh), int'(cfg));
      chk(n_valid == nv0 + 1, "R9 busy start ignored", n_valid - nv0, 1);
    end
    prev_cfg = cfg;
    cfg_word = cfg;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", nc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k, nv0, d;
    k = 0;
    repeat (3) @(negedge clk);
    chk(!cnv && !sck && !din && !valid && rdata == 0 && rcfg == 0,
        "R1 reset outputs", int'({cnv, sck, din, valid}), 0);
    @(negedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!cnv && !sck && !din && !valid, "R1 first cycle after reset",
        int'({cnv, sck, din, valid}), 0);

    run_one(1, 1, 1'b0, 14'h0000, 14'h3FFF, 1'b0);
    run_one(2, 2, 1'b1, 14'h3FFF, 14'h0000, 1'b0);
    foreach (conv_set[i]) begin end
    for (int ti = 0; ti < 3; ti++) begin
      for (int hi = 0; hi < 3; hi++) begin
        for (int rb = 0; rb < 2; rb++) begin
          logic [13:0] c, r;
          c = 14'(k * 183 + 4660);
          r = 14'((k * 467) ^ 10922);
          run_one(ti == 0 ? 1 : (ti == 1 ? 2 : 5), hi == 2 ? 3 : hi,
                  rb[0], c, r, (k % 3) == 0);
          k++;
        end
      end
    end

    // start spacing limited by min_cycle
    min_cycle = 16'd300;
    conv_ticks = 16'd2;
    half_ticks = 8'd1;
    rdback_en = 1'b0;
    cfg_word = 14'h0155;
    @(negedge clk); #1;
    nv0 = n_valid;
    start = 1'b1;
    while (n_valid < nv0 + 2) @(negedge clk);
    #1;
    start = 1'b0;
    chk(t_valid - t_valid_prev == 300, "R9 spacing set by min_cycle",
        t_valid - t_valid_prev, 300);
    repeat (400) @(negedge clk);

    // start spacing limited by the transfer length
    min_cycle = 16'd4;
    d = 1 + 2 + 2 * 14 * 1;
    @(negedge clk); #1;
    nv0 = n_valid;
    start = 1'b1;
    while (n_valid < nv0 + 2) @(negedge clk);
    #1;
    start = 1'b0;
    chk(t_valid - t_valid_prev == d + 2, "R9 spacing set by transfer",
        t_valid - t_valid_prev, d + 2);
    repeat (100) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int conv_set[1];
endmodule